// File: doc/BRIEF.md
# Receiver Detect Handshake Sequencer

This block runs the handshake by which a link controller asks the physical layer whether a receiver is attached at the far end of the link. The controller raises a detect request while the physical layer sits in its low-power P1 state. The sequencer then holds a measurement-enable line high until an abstracted measurement source returns a done flag and a present flag. The time that source takes is set by whatever drives it.

The outcome is published as a 3-bit receive status code. One cycle later a completion level is raised. The controller samples the status on the rising edge of that level and then drops its request. After a fixed, parameterised number of cycles the sequencer lowers the completion level, returns the status to zero, and is idle again. The completion signal is held as a level for the whole wait, not pulsed.

The controller states are ST_IDLE, ST_MEASURE, ST_REPORT, ST_HOLD and ST_RELEASE. The transitions are:
- ST_IDLE to ST_MEASURE on request in P1.
- ST_MEASURE to ST_IDLE when the request drops (abort).
- ST_MEASURE to ST_REPORT on done.
- ST_REPORT to ST_HOLD unconditionally.
- ST_HOLD to ST_RELEASE when the request drops.
- ST_RELEASE to ST_IDLE when the release delay has elapsed.

Top module: `rxdet_handshake_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are as follows: `rx_status` = 3'b000, `phy_status` = 0, `meas_busy` = 0.
- R2: A sequence starts only when `det_req` is high at a clock edge and the power code is P1. The power codes are 2'b00 for P0, 2'b01 for P0s and 2'b10 for P1. When a sequence starts, `meas_busy` is high after that edge. A request under P0 or P0s leaves `meas_busy` and `phy_status` low and `rx_status` at 3'b000.
- R3: Power code 2'b11 is treated exactly like P1.
- R4: `meas_busy` stays high until the edge that samples `meas_done` high, and then falls. `meas_busy` and `phy_status` are never high together.
- R5: From the cycle after that edge, `rx_status` is 3'b011 if `meas_present` was high at that edge, and 3'b000 otherwise. No other code ever appears.
- R6: `phy_status` rises exactly one cycle after `rx_status` becomes valid, so the status is already stable at its rising edge.
- R7: While `det_req` remains high, `phy_status` stays high and `rx_status` does not change, whatever `meas_done` and `meas_present` do.
- R8: `phy_status` falls RELEASE_DLY clock edges after the edge that first samples `det_req` low. `rx_status` keeps the result until then and returns to 3'b000 in the same cycle as `phy_status` falls.
- R9: If `det_req` drops while the measurement is running, the sequence is abandoned. The sequencer returns to idle without ever raising `phy_status`, and the status stays 3'b000.
- R10: Outside a running measurement, `meas_done` and `meas_present` have no effect: the outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_state | input | 2 | Current power-state code from the controller |
| det_req | input | 1 | Detect request level from the controller |
| meas_done | input | 1 | Measurement result valid flag |
| meas_present | input | 1 | Far-end receiver found, valid with meas_done |
| meas_busy | output | 1 | Measurement enable, high while waiting for a result |
| rx_status | output | 3 | Receive status code (3'b011 found, 3'b000 otherwise) |
| phy_status | output | 1 | Completion level, held until the release delay ends |

## Verification
The bench builds the block with RELEASE_DLY = 3 instead of the default 2. This makes the release counter step through an intermediate value, so an off-by-one in the count is exposed by a completion level that ends one cycle early or late. The random transactions vary the measurement latency from zero to several cycles, the hold time before release, the power code, and the chance of an abort. A zero-latency measurement and all four power codes are therefore covered. The inputs are toggled on purpose during hold and idle to show that they are ignored there.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_REPORT,
        ST_HOLD,
        ST_RELEASE
    } seq_state_t;

    localparam logic [2:0] RXST_NONE  = 3'b000;
    localparam logic [2:0] RXST_FOUND = 3'b011;

    localparam logic [1:0] PD_P0   = 2'b00;
    localparam logic [1:0] PD_P0S  = 2'b01;
    localparam logic [1:0] PD_P1   = 2'b10;
    localparam logic [1:0] PD_RSVD = 2'b11;

endpackage

// File: rtl/rxdet_pwr_decode.sv
module rxdet_pwr_decode
    import rxdet_pkg::*;
(
    input  logic [1:0] pwr_state,
    output logic       in_p1
);
    // The reserved code falls back to the P1 behaviour.
    always_comb begin
        unique case (pwr_state)
            PD_P0:   in_p1 = 1'b0;
            PD_P0S:  in_p1 = 1'b0;
            PD_P1:   in_p1 = 1'b1;
            PD_RSVD: in_p1 = 1'b1;
            default: in_p1 = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxdet_result_reg.sv
module rxdet_result_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic clear,
    input  logic present_in,
    output logic present_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_q <= 1'b0;
        end else if (clear) begin
            present_q <= 1'b0;
        end else if (capture) begin
            present_q <= present_in;
        end
    end

    // Result is frozen except at capture or clear
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !clear) |=> $stable(present_q)); // R7
endmodule

// File: rtl/rxdet_release_timer.sv
module rxdet_release_timer #(
    parameter int RELEASE_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (RELEASE_DLY > 1) ? $clog2(RELEASE_DLY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_DLY - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8

    initial begin
        if (RELEASE_DLY < 1) $error("RELEASE_DLY must be at least 1");
    end
endmodule

// File: rtl/rxdet_handshake_seq.sv
module rxdet_handshake_seq
    import rxdet_pkg::*;
#(
    parameter int RELEASE_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_state,
    input  logic       det_req,
    input  logic       meas_done,
    input  logic       meas_present,
    output logic       meas_busy,
    output logic [2:0] rx_status,
    output logic       phy_status
);
    seq_state_t state_q, state_d;
    logic       in_p1;
    logic       present_q;
    logic       rel_expired;
    logic       res_capture;
    logic       res_clear;
    logic       rel_load;
    logic       rel_run;

    rxdet_pwr_decode u_pwr (
        .pwr_state (pwr_state),
        .in_p1     (in_p1)
    );

    assign res_capture = (state_q == ST_MEASURE) && det_req && meas_done;
    assign res_clear   = (state_q == ST_IDLE);

    rxdet_result_reg u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (res_capture),
        .clear      (res_clear),
        .present_in (meas_present),
        .present_q  (present_q)
    );

    assign rel_load = (state_q == ST_HOLD) && !det_req;
    assign rel_run  = (state_q == ST_RELEASE);

    rxdet_release_timer #(.RELEASE_DLY(RELEASE_DLY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rel_load),
        .run     (rel_run),
        .expired (rel_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (det_req && in_p1) state_d = ST_MEASURE;
            ST_MEASURE: begin
                if (!det_req)       state_d = ST_IDLE;
                else if (meas_done) state_d = ST_REPORT;
            end
            ST_REPORT:  state_d = ST_HOLD;
            ST_HOLD:    if (!det_req) state_d = ST_RELEASE;
            ST_RELEASE: if (rel_expired) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        meas_busy  = 1'b0;
        phy_status = 1'b0;
        rx_status  = RXST_NONE;
        unique case (state_q)
            ST_IDLE:    ;
            ST_MEASURE: meas_busy = 1'b1;
            ST_REPORT:  rx_status = present_q ? RXST_FOUND : RXST_NONE;
            ST_HOLD: begin
                phy_status = 1'b1;
                rx_status  = present_q ? RXST_FOUND : RXST_NONE;
            end
            ST_RELEASE: begin
                phy_status = 1'b1;
                rx_status  = present_q ? RXST_FOUND : RXST_NONE;
            end
            default: ;
        endcase
    end

    AST_NO_START_OUTSIDE_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !in_p1) |=> !meas_busy); // R2
    AST_BUSY_PHY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_busy && phy_status)); // R4
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_status == RXST_NONE) || (rx_status == RXST_FOUND)); // R5
    AST_STATUS_BEFORE_PHY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_status) |-> $stable(rx_status)); // R6
    AST_PHY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && det_req) |=> phy_status); // R7
    AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_status && $past(phy_status)) |-> $stable(rx_status)); // R7
    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_status) |-> (rx_status == RXST_NONE)); // R8
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !det_req) |=> !phy_status && !meas_busy); // R9
endmodule

// File: tb/rxdet_handshake_seq_tb.sv
`timescale 1ns/1ps
module rxdet_handshake_seq_tb;
    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic       det_req = 1'b0;
    logic       meas_done = 1'b0;
    logic       meas_present = 1'b0;
    logic       meas_busy;
    logic [2:0] rx_status;
    logic       phy_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    rxdet_handshake_seq #(.RELEASE_DLY(DLY)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_state    (pwr_state),
        .det_req      (det_req),
        .meas_done    (meas_done),
        .meas_present (meas_present),
        .meas_busy    (meas_busy),
        .rx_status    (rx_status),
        .phy_status   (phy_status)
    );

    function automatic logic [2:0] exp_status(input logic present);
        return present ? 3'b011 : 3'b000;
    endfunction

    function automatic bit starts_in(input logic [1:0] pw);
        return pw[1];
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        chk(meas_busy, 0, req, "meas_busy idle");
        chk(phy_status, 0, req, "phy_status idle");
        chk(rx_status, 0, req, "rx_status idle");
    endtask

    task automatic run_txn(input logic [1:0] pw, input int mdly, input logic pres,
                           input int hold, input bit abort_it);
        string sreq;
        sreq = (pw == 2'b11) ? "R3" : "R2";
        @(negedge clk);
        pwr_state = pw;
        det_req   = 1'b1;
        meas_done = 1'b0;
        @(negedge clk);
        if (!starts_in(pw)) begin
            for (int i = 0; i < 3; i++) begin
                idle_check("R2");
                @(negedge clk);
            end
            det_req = 1'b0;
            @(negedge clk);
            return;
        end
        chk(meas_busy, 1, sreq, "meas_busy after start");
        chk(phy_status, 0, "R4", "phy_status during measure");
        for (int i = 0; i < mdly; i++) begin
            @(negedge clk);
            chk(meas_busy, 1, "R4", "meas_busy waiting");
            chk(rx_status, 0, "R4", "rx_status waiting");
        end
        if (abort_it) begin
            det_req = 1'b0;
            meas_done = 1'b1;
            @(negedge clk);
            meas_done = 1'b0;
            idle_check("R9");
            @(negedge clk);
            idle_check("R9");
            return;
        end
        meas_done    = 1'b1;
        meas_present = pres;
        @(negedge clk);
        meas_done    = 1'b0;
        meas_present = ~pres;
        chk(rx_status, exp_status(pres), "R5", "status after done");
        chk(phy_status, 0, "R6", "phy_status in report cycle");
        chk(meas_busy, 0, "R4", "meas_busy after done");
        @(negedge clk);
        chk(phy_status, 1, "R6", "phy_status rise");
        chk(rx_status, exp_status(pres), "R7", "status at rise");
        for (int i = 0; i < hold; i++) begin
            meas_done    = 1'($urandom_range(0, 1));
            meas_present = 1'($urandom_range(0, 1));
            @(negedge clk);
            chk(phy_status, 1, "R7", "phy_status held");
            chk(rx_status, exp_status(pres), "R7", "status held");
        end
        meas_done = 1'b0;
        det_req   = 1'b0;
        for (int i = 0; i < DLY; i++) begin
            @(negedge clk);
            chk(phy_status, 1, "R8", "phy_status in release");
            chk(rx_status, exp_status(pres), "R8", "status in release");
        end
        @(negedge clk);
        chk(phy_status, 0, "R8", "phy_status fall");
        chk(rx_status, 0, "R8", "status cleared");
    endtask

    initial begin
        process::self().srandom(32'h5eed_0017);
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1");

        // R10: stray measurement flags while idle
        meas_done = 1'b1; meas_present = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            idle_check("R10");
        end
        meas_done = 1'b0; meas_present = 1'b0;

        // Directed corners
        run_txn(2'b10, 0, 1'b1, 0, 1'b0);
        run_txn(2'b10, 4, 1'b0, 2, 1'b0);
        run_txn(2'b11, 1, 1'b1, 1, 1'b0);
        run_txn(2'b00, 0, 1'b1, 0, 1'b0);
        run_txn(2'b01, 0, 1'b1, 0, 1'b0);
        run_txn(2'b10, 2, 1'b1, 0, 1'b1);
        run_txn(2'b10, 0, 1'b1, 0, 1'b1);

        // Constrained random
        for (int t = 0; t < 60; t++) begin
            logic [1:0] pw;
            pw = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
            run_txn(pw, int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 5)), ($urandom_range(0, 5) == 0));
            if ($urandom_range(0, 1) == 1) @(negedge clk);
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule